// File: doc/BRIEF.md
# Delta-Modulation Sample Fetch and Control

This block is the register and memory-request half of a delta-modulation audio channel. Software writes a control register, an output-level register, a start-address register and a length register, plus a status register that is shared with other channels. The block keeps the current sample address and the number of bytes still to fetch. Whenever its one-byte sample buffer is empty and bytes remain, it asks a DMA arbiter for the next byte.

The output stage sits outside this block. It empties the buffer through an empty/take handshake and runs at the rate period that this block selects and passes on. When a sample ends, the block either starts it again from the stored start values or raises its interrupt, depending on the control bits. A status read gives the interrupt flag and whether any bytes remain.

Top module: `sample_fetch_ctl`

## Requirements
- R1: A write with `regSel`=0 loads the control register. Bits [3:0] select `ratePeriod` from the table 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54, in code order 0 to 15. Bit 6 enables looping and bit 7 enables the interrupt.
- R2: A write with `regSel`=2 stores value v. On the next restart, the first fetch address is 0xC000 + 64*v.
- R3: A write with `regSel`=3 stores value n. A restart then fetches exactly 16*n+1 bytes and stops. After that, status bit 4 reads 0 and no further request is raised.
- R4: Each accepted byte moves the address up by one. From 0xFFFF the address goes to 0x8000.
- R5: With looping enabled, the last byte of a sample reloads the start address and the length, and fetching continues. The interrupt flag stays clear.
- R6: With looping disabled and the interrupt enabled, the last byte sets the interrupt flag and `irq` rises. With the interrupt disabled, the flag stays clear.
- R7: A control write with bit 7 = 0 clears a pending interrupt flag.
- R8: Any status write clears the interrupt flag. A status write with bit 4 = 0 sets the remaining count to 0. A request that is already raised is still completed, and no new request follows.
- R9: A status write with bit 4 = 1 restarts the sample only if the remaining count is 0. Otherwise the address and the count carry on unchanged.
- R10: `statusRdData` gives the interrupt flag in bit 7 and (remaining count > 0) in bit 4. All other bits are 0.
- R11: `fetchReq` rises only while the buffer is empty and bytes remain, and it stays high until `fetchAck`. An acknowledged byte appears on `bufData` with `bufEmpty` low, and no request follows until `bufTake`.
- R12: A write with `regSel`=1 pulses `levelWr` for one cycle, one clock after the write, and `levelVal` carries data bits [6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Channel register write strobe |
| regSel | input | 2 | Channel register select (0 control, 1 level, 2 address, 3 length) |
| statusWrEn | input | 1 | Shared status register write strobe |
| wrData | input | 8 | Write data |
| statusRdData | output | 8 | Channel bits of the status register |
| fetchReq | output | 1 | Byte request to the DMA arbiter |
| fetchAddr | output | 16 | Address of the requested byte |
| fetchAck | input | 1 | Arbiter returns the byte this cycle |
| fetchData | input | 8 | Returned byte |
| bufEmpty | output | 1 | Sample buffer holds no byte |
| bufTake | input | 1 | Output stage takes the buffered byte |
| bufData | output | 8 | Buffered byte |
| ratePeriod | output | 9 | Selected rate period in input clocks |
| levelWr | output | 1 | Direct level load pulse to the output stage |
| levelVal | output | 7 | Direct level value |
| irq | output | 1 | Channel interrupt (flag and enable) |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit address and length fields, and an 8-bit sample byte. At this size every one of the 256 start-address values can be swept in one run. Every rate code and every length value from 0 to 7 (up to 113 bytes) can also be swept, with each fetch address checked against arithmetic in the bench. A start-address value of 0xFF with a 65-byte sample crosses the top of memory, so the wrap to 0x8000 can be reached directly.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int RATE_W = 9;

  typedef struct packed {
    logic restart;
    logic clearCount;
    logic acceptByte;
    logic reloadLoop;
  } strobe_t;

  function automatic logic [RATE_W-1:0] rateLookup(input logic [3:0] code);
    logic [RATE_W-1:0] p;
    case (code)
      4'd0:  p = 9'd428;
      4'd1:  p = 9'd380;
      4'd2:  p = 9'd340;
      4'd3:  p = 9'd320;
      4'd4:  p = 9'd286;
      4'd5:  p = 9'd254;
      4'd6:  p = 9'd226;
      4'd7:  p = 9'd214;
      4'd8:  p = 9'd190;
      4'd9:  p = 9'd160;
      4'd10: p = 9'd142;
      4'd11: p = 9'd128;
      4'd12: p = 9'd106;
      4'd13: p = 9'd84;
      4'd14: p = 9'd72;
      default: p = 9'd54;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic              statusWrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fetchAck,
  input  logic              bufTake,
  input  logic              countZero,
  input  logic              lastByte,
  output strobe_t           strb,
  output logic              fetchReq,
  output logic              bufEmpty,
  output logic              irqFlag,
  output logic              irq
);

  localparam int IRQ_BIT  = 7;
  localparam int LOOP_BIT = 6;
  localparam int RUN_BIT  = 4;

  logic irqEn;
  logic loopEn;
  logic reqPend;
  logic bufFull;
  logic ctrlWr;

  assign ctrlWr = regWrEn && (regSel == 2'd0);

  always_comb begin
    strb.acceptByte = fetchAck && reqPend;
    strb.reloadLoop = strb.acceptByte && lastByte && loopEn;
    strb.clearCount = statusWrEn && !wrData[RUN_BIT];
    strb.restart    = statusWrEn && wrData[RUN_BIT] && countZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn  <= 1'b0;
      loopEn <= 1'b0;
    end else if (ctrlWr) begin
      irqEn  <= wrData[IRQ_BIT];
      loopEn <= wrData[LOOP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPend <= 1'b0;
    end else if (strb.acceptByte) begin
      reqPend <= 1'b0;
    end else if (!reqPend && !bufFull && !countZero) begin
      reqPend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull <= 1'b0;
    end else if (strb.acceptByte) begin
      bufFull <= 1'b1;
    end else if (bufTake) begin
      bufFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (strb.acceptByte && lastByte && !loopEn && irqEn) begin
      irqFlag <= 1'b1;
    end else if (statusWrEn || (ctrlWr && !wrData[IRQ_BIT])) begin
      irqFlag <= 1'b0;
    end
  end

  assign fetchReq = reqPend;
  assign bufEmpty = !bufFull;
  assign irq      = irqFlag && irqEn;

  // R11: a raised request is held until the arbiter answers
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchAck |=> fetchReq);

  // R11: never request while a byte waits in the buffer
  p_req_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> bufEmpty);

  // R6: the flag only rises on an accepted byte
  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(fetchAck));

  // R7: clearing the enable drops the flag
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !wrData[IRQ_BIT] |=> !irqFlag);

endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int AREG_W     = 8,
  parameter int LREG_W     = 8,
  parameter int ADDR_SHIFT = 6,
  parameter int LEN_SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] fetchData,
  input  strobe_t           strb,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [DATA_W-1:0] bufData,
  output logic              countZero,
  output logic              lastByte,
  output logic [RATE_W-1:0] ratePeriod,
  output logic              levelWr,
  output logic [DATA_W-2:0] levelVal
);

  localparam int CNT_W = LREG_W + LEN_SHIFT;
  localparam logic [ADDR_W-1:0] START_BASE = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] WRAP_BASE  = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] ADDR_TOP   = {ADDR_W{1'b1}};

  logic [3:0]        rateCode;
  logic [AREG_W-1:0] addrReg;
  logic [LREG_W-1:0] lenReg;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] startAddr;
  logic [CNT_W-1:0]  startLen;
  logic [ADDR_W-1:0] nextAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCode <= '0;
      addrReg  <= '0;
      lenReg   <= '0;
      levelWr  <= 1'b0;
      levelVal <= '0;
    end else begin
      levelWr <= regWrEn && (regSel == 2'd1);
      if (regWrEn) begin
        case (regSel)
          2'd0: rateCode <= wrData[3:0];
          2'd1: levelVal <= wrData[DATA_W-2:0];
          2'd2: addrReg  <= wrData[AREG_W-1:0];
          default: lenReg <= wrData[LREG_W-1:0];
        endcase
      end
    end
  end

  always_comb begin
    startAddr = START_BASE | (ADDR_W'(addrReg) << ADDR_SHIFT);
    startLen  = (CNT_W'(lenReg) << LEN_SHIFT) + CNT_W'(1);
    nextAddr  = (curAddr == ADDR_TOP) ? WRAP_BASE : curAddr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= START_BASE;
    end else if (strb.restart) begin
      curAddr <= startAddr;
    end else if (strb.acceptByte) begin
      curAddr <= (strb.reloadLoop && !strb.clearCount) ? startAddr : nextAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (strb.clearCount) begin
      remain <= '0;
    end else if (strb.restart) begin
      remain <= startLen;
    end else if (strb.acceptByte) begin
      if (strb.reloadLoop) begin
        remain <= startLen;
      end else if (remain != '0) begin
        remain <= remain - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData <= '0;
    end else if (strb.acceptByte) begin
      bufData <= fetchData;
    end
  end

  assign fetchAddr  = curAddr;
  assign countZero  = (remain == '0);
  assign lastByte   = (remain == CNT_W'(1));
  assign ratePeriod = rateLookup(rateCode);

  // R4: stepping past the top lands at the bottom of the upper half
  p_addr_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.acceptByte && !strb.reloadLoop && !strb.restart && curAddr == ADDR_TOP
    |=> curAddr == WRAP_BASE);

  // R8: a stop write leaves nothing to fetch
  p_stop_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCount |=> countZero);

  // R9: a restart is only taken from an empty count
  p_restart_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |-> countZero);

  // R3: the count never moves while no byte arrives and no write occurs
  p_count_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.acceptByte && !strb.restart && !strb.clearCount |=> $stable(remain));

endmodule

// File: rtl/sample_fetch_ctl.sv
module sample_fetch_ctl
  import sfc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int AREG_W     = 8,
  parameter int LREG_W     = 8,
  parameter int ADDR_SHIFT = 6,
  parameter int LEN_SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic              statusWrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusRdData,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchAck,
  input  logic [DATA_W-1:0] fetchData,
  output logic              bufEmpty,
  input  logic              bufTake,
  output logic [DATA_W-1:0] bufData,
  output logic [RATE_W-1:0] ratePeriod,
  output logic              levelWr,
  output logic [DATA_W-2:0] levelVal,
  output logic              irq
);

  strobe_t strb;
  logic    countZero;
  logic    lastByte;
  logic    irqFlag;

  sfc_control #(.DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .statusWrEn (statusWrEn),
    .wrData     (wrData),
    .fetchAck   (fetchAck),
    .bufTake    (bufTake),
    .countZero  (countZero),
    .lastByte   (lastByte),
    .strb       (strb),
    .fetchReq   (fetchReq),
    .bufEmpty   (bufEmpty),
    .irqFlag    (irqFlag),
    .irq        (irq)
  );

  sfc_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .AREG_W     (AREG_W),
    .LREG_W     (LREG_W),
    .ADDR_SHIFT (ADDR_SHIFT),
    .LEN_SHIFT  (LEN_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .wrData     (wrData),
    .fetchData  (fetchData),
    .strb       (strb),
    .fetchAddr  (fetchAddr),
    .bufData    (bufData),
    .countZero  (countZero),
    .lastByte   (lastByte),
    .ratePeriod (ratePeriod),
    .levelWr    (levelWr),
    .levelVal   (levelVal)
  );

  always_comb begin
    statusRdData    = '0;
    statusRdData[7] = irqFlag;
    statusRdData[4] = !countZero;
  end

endmodule

// File: tb/sample_fetch_ctl_tb.sv
module sample_fetch_ctl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        statusWrEn = 1'b0;
  logic [7:0]  wrData = 8'd0;
  logic [7:0]  statusRdData;
  logic        fetchReq;
  logic [15:0] fetchAddr;
  logic        fetchAck = 1'b0;
  logic [7:0]  fetchData = 8'd0;
  logic        bufEmpty;
  logic        bufTake = 1'b0;
  logic [7:0]  bufData;
  logic [8:0]  ratePeriod;
  logic        levelWr;
  logic [6:0]  levelVal;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sample_fetch_ctl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .statusWrEn(statusWrEn), .wrData(wrData), .statusRdData(statusRdData),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchAck(fetchAck),
    .fetchData(fetchData), .bufEmpty(bufEmpty), .bufTake(bufTake),
    .bufData(bufData), .ratePeriod(ratePeriod), .levelWr(levelWr),
    .levelVal(levelVal), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic statusWrite(input logic [7:0] d);
    @(negedge clk);
    statusWrEn = 1'b1; wrData = d;
    @(negedge clk);
    statusWrEn = 1'b0;
  endtask

  task automatic serveFetch(input logic [15:0] expAddr, input bit chkAddr, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (fetchReq) begin seen = 1'b1; break; end
    end
    check(seen, req, 0, 1);
    if (chkAddr) check(fetchAddr == expAddr, req, fetchAddr, expAddr);
    fetchAck = 1'b1; fetchData = expAddr[7:0] ^ 8'h3C;
    @(negedge clk);
    fetchAck = 1'b0;
    bufTake = 1'b1;
    @(negedge clk);
    bufTake = 1'b0;
  endtask

  task automatic expectIdle(input string req);
    bit anyReq = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (fetchReq) anyReq = 1'b1;
    end
    check(!anyReq, req, anyReq, 0);
    check(statusRdData[4] == 1'b0, req, statusRdData[4], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    automatic int rateTab[16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                                  190, 160, 142, 128, 106, 84, 72, 54};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 / R11: reset state
    check(statusRdData == 8'h00, "R10 reset status", statusRdData, 0);
    check(!fetchReq && bufEmpty, "R11 reset idle", {fetchReq, bufEmpty}, 1);
    check(!irq, "R6 reset irq", irq, 0);

    // R1: every rate code
    for (int c = 0; c < 16; c++) begin
      regWrite(2'd0, 8'(c));
      check(ratePeriod == 9'(rateTab[c]), "R1 rate", ratePeriod, rateTab[c]);
    end

    // R12: level pass-through
    @(negedge clk);
    regWrEn = 1'b1; regSel = 2'd1; wrData = 8'hD5;
    @(negedge clk);
    regWrEn = 1'b0;
    check(levelWr && levelVal == 7'h55, "R12 level", {levelWr, levelVal}, {1'b1, 7'h55});
    @(negedge clk);
    check(!levelWr, "R12 pulse width", levelWr, 0);

    // R2: all start address values, one-byte samples
    regWrite(2'd0, 8'h00);
    regWrite(2'd3, 8'h00);
    for (int v = 0; v < 256; v++) begin
      regWrite(2'd2, 8'(v));
      statusWrite(8'h10);
      serveFetch(16'hC000 + 16'(v * 64), 1'b1, "R2 start address");
      check(statusRdData[4] == 1'b0, "R3 one-byte end", statusRdData[4], 0);
    end

    // R3: lengths 0..7, each address in order
    regWrite(2'd2, 8'h00);
    for (int n = 0; n < 8; n++) begin
      regWrite(2'd3, 8'(n));
      statusWrite(8'h10);
      check(statusRdData[4] == 1'b1, "R10 busy bit", statusRdData[4], 1);
      for (int i = 0; i < 16 * n + 1; i++)
        serveFetch(16'hC000 + 16'(i), 1'b1, "R3 sequence");
      expectIdle("R3 stop after length");
    end

    // R4: wrap from 0xFFFF to 0x8000
    regWrite(2'd2, 8'hFF);
    regWrite(2'd3, 8'h04);
    statusWrite(8'h10);
    for (int i = 0; i < 64; i++)
      serveFetch(16'hFFC0 + 16'(i), 1'b1, "R4 top run");
    serveFetch(16'h8000, 1'b1, "R4 wrap");
    expectIdle("R4 end");

    // R5: looping one-byte sample
    regWrite(2'd0, 8'h40);
    regWrite(2'd2, 8'h10);
    regWrite(2'd3, 8'h00);
    statusWrite(8'h10);
    for (int i = 0; i < 3; i++)
      serveFetch(16'hC400, 1'b1, "R5 loop address");
    check(statusRdData == 8'h10, "R5 still busy no irq", statusRdData, 8'h10);

    // R6: loop off, irq on -> flag at end
    regWrite(2'd0, 8'h80);
    serveFetch(16'hC400, 1'b1, "R6 last byte");
    check(irq && statusRdData == 8'h80, "R6 irq set", {irq, statusRdData}, {1'b1, 8'h80});

    // R7: clearing enable clears flag
    regWrite(2'd0, 8'h00);
    check(!irq && statusRdData == 8'h00, "R7 irq cleared", {irq, statusRdData}, 0);

    // R8: status write clears flag
    regWrite(2'd0, 8'h80);
    statusWrite(8'h10);
    serveFetch(16'hC400, 1'b1, "R6 second end");
    check(irq, "R6 irq set again", irq, 1);
    statusWrite(8'h00);
    check(!irq && statusRdData[7] == 1'b0, "R8 status clears irq", statusRdData, 0);

    // R6: interrupt disabled -> no flag
    regWrite(2'd0, 8'h00);
    statusWrite(8'h10);
    serveFetch(16'hC400, 1'b1, "R6 disabled fetch");
    check(!irq && statusRdData == 8'h00, "R6 no irq when disabled", statusRdData, 0);

    // R8: stop mid-sample, pending request still served
    regWrite(2'd2, 8'h00);
    regWrite(2'd3, 8'h07);
    statusWrite(8'h10);
    serveFetch(16'hC000, 1'b1, "R8 first");
    serveFetch(16'hC001, 1'b1, "R8 second");
    statusWrite(8'h00);
    check(statusRdData[4] == 1'b0, "R8 count forced zero", statusRdData[4], 0);
    check(fetchReq, "R8 pending request held", fetchReq, 1);
    serveFetch(16'hC002, 1'b1, "R8 pending address");
    expectIdle("R8 no new request");

    // R9: restart ignored while bytes remain
    statusWrite(8'h10);
    serveFetch(16'hC000, 1'b1, "R9 first");
    serveFetch(16'hC001, 1'b1, "R9 second");
    regWrite(2'd2, 8'h20);
    statusWrite(8'h10);
    serveFetch(16'hC002, 1'b1, "R9 continues, no restart");
    check(statusRdData[4] == 1'b1, "R9 still busy", statusRdData[4], 1);
    statusWrite(8'h00);
    serveFetch(16'h0000, 1'b0, "R9 drain");
    expectIdle("R9 stopped");

    // R11: full buffer blocks requests
    regWrite(2'd2, 8'h00);
    regWrite(2'd3, 8'h01);
    statusWrite(8'h10);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (fetchReq) break;
    end
    check(fetchReq && fetchAddr == 16'hC000, "R11 request", fetchAddr, 16'hC000);
    fetchAck = 1'b1; fetchData = 8'hA7;
    @(negedge clk);
    fetchAck = 1'b0;
    check(!bufEmpty && bufData == 8'hA7, "R11 byte buffered", bufData, 8'hA7);
    begin
      bit anyReq = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (fetchReq) anyReq = 1'b1;
      end
      check(!anyReq, "R11 no request while full", anyReq, 0);
    end
    bufTake = 1'b1;
    @(negedge clk);
    bufTake = 1'b0;
    check(bufEmpty, "R11 take empties", bufEmpty, 1);
    serveFetch(16'hC001, 1'b1, "R11 next after take");
    statusWrite(8'h00);
    serveFetch(16'h0000, 1'b0, "R11 drain");
    expectIdle("R11 end");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule